// File: doc/BRIEF.md
# Character Synchronization Tracker for an 8b/10b Receiver

This block follows whether an 8b/10b receive path is locked to the character stream. An upstream decoder and word aligner hand it one strobe per received 10-bit character. With each strobe come four flags:

- the character was a bad code or had a disparity error;
- the character was one of the accepted comma symbols (K28.1, K28.5, K28.7);
- the word aligner moved the 10-bit boundary on this character;
- the word-sync sequence was recognised.

From these the block walks a three-state machine: lost, resynchronising and locked. It also forces the idle, error and control-character status toward the downstream logic.

Two counters decide when lock is lost. A run counter counts bad characters in a row. A saturating up/down balance counter goes up by one on every bad character and down by one on every good one. Both a comma with a shifted boundary and the word-sync sequence send a locked receiver back to resynchronising. A mode input turns the tracker off, and while it is off the decoder status is passed through untouched.

Top module: `rx_sync_fsm`

## Requirements
- R1: The state port encodes lost as 0, resynchronising as 1 and locked as 2. Value 3 never appears. After reset the state is 0 and the flags are idle=0, error=1, control=1.
- R2: Lost is left only for resynchronising, and only on a strobed character with the comma flag set and the bad flag clear.
- R3: Resynchronising moves to locked only on a strobed character with both the bad flag and the comma flag clear. Commas, shifted commas and a lone bad character leave it resynchronising.
- R4: Locked goes to resynchronising on the fourth good comma in a row. Any other strobed character restarts that run.
- R5: Locked goes to resynchronising on a single good comma that comes with the boundary-moved flag, or on any strobed character with the word-sync flag.
- R6: Four strobed bad characters in a row move any state to lost.
- R7: The balance counter rises on a bad character, falls on any other strobed character and never goes below zero. When it reaches four the state goes to lost and both loss counters clear.
- R8: Flags in resynchronising are idle=1, error=1, control=1. In lost they are idle=0, error=1, control=1. In locked, error=0 and idle and control follow the decoder. A bad character that leaves the machine locked reports error=1, control=0 and idle from the decoder.
- R9: A cycle with the strobe low changes no state or counter.
- R10: With the mode input low, the state is held at lost and all counters clear. The three flags then repeat the decoder flags.
- R11: A character that is bad and is also a shifted comma, arriving when it completes a loss condition, sends the machine to lost, not to resynchronising.
- R12: State and flags are registered. A character strobed in one cycle shows up on the outputs after the next rising clock edge, and never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_en | input | 1 | Mode input; low disables the tracker |
| chr_stb | input | 1 | One received character is presented this cycle |
| chr_bad | input | 1 | Character has a bad code or disparity error |
| chr_comma | input | 1 | Character is an accepted comma symbol |
| frame_moved | input | 1 | Aligner shifted the 10-bit boundary on this character |
| wsync_hit | input | 1 | Word-sync sequence recognised |
| dec_idle | input | 1 | Idle status from the decoder |
| dec_err | input | 1 | Error status from the decoder |
| dec_ctl | input | 1 | Control-character status from the decoder |
| st_o | output | 2 | Current state (0 lost, 1 resynchronising, 2 locked) |
| idle_o | output | 1 | Idle status after override |
| err_o | output | 1 | Error status after override |
| ctl_o | output | 1 | Control-character status after override |

## Verification
The properties assume that the qualifier flags only count when the strobe is high. They also assume that a character flagged bad is never treated as a good comma, even when the comma flag is set with it.

The stimulus raises the flags with the strobe low in one case only, to show they are ignored there. It sets bad and comma together in one case only, to check which condition wins.

The disable properties compare the outputs with decoder inputs from one cycle earlier. For that reason the bench holds the decoder flags steady across each character slot.

// File: rtl/rx_sync_pkg.sv
package rx_sync_pkg;

  typedef enum logic [1:0] {
    ST_LOST   = 2'd0,
    ST_RESYNC = 2'd1,
    ST_LOCKED = 2'd2
  } sync_st_e;

  typedef struct packed {
    logic idle;
    logic err;
    logic ctl;
  } rx_flags_t;

  localparam rx_flags_t FLAGS_LOST   = '{idle: 1'b0, err: 1'b1, ctl: 1'b1};
  localparam rx_flags_t FLAGS_RESYNC = '{idle: 1'b1, err: 1'b1, ctl: 1'b1};

endpackage

// File: rtl/rx_sync_runcnt.sv
// Counts consecutive qualifying characters; fires on the LIMIT-th one.
module rx_sync_runcnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  input  logic hit,
  output logic fire
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  assign fire = adv && hit && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (adv) begin
      if (hit && !fire) cnt <= cnt + 1'b1;
      else              cnt <= '0;
    end
  end
endmodule

// File: rtl/rx_sync_balance.sv
// Saturating up/down counter of bad versus good characters.
module rx_sync_balance #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  input  logic up,
  output logic fire
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  assign fire = adv && up && (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (adv) begin
      if (up)              cnt <= fire ? '0 : cnt + 1'b1;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rx_sync_flags.sv
// Registered status override, driven from the state the machine moves to.
module rx_sync_flags
  import rx_sync_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  sync_st_e  st_nx,
  input  logic      bad_now,
  input  rx_flags_t dec,
  output rx_flags_t flags_q
);
  rx_flags_t f_d;

  always_comb begin
    if (!en) begin
      f_d = dec;
    end else begin
      unique case (st_nx)
        ST_RESYNC: f_d = FLAGS_RESYNC;
        ST_LOCKED: f_d = bad_now ? '{idle: dec.idle, err: 1'b1, ctl: 1'b0}
                                 : '{idle: dec.idle, err: 1'b0, ctl: dec.ctl};
        default:   f_d = FLAGS_LOST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= FLAGS_LOST;
    else     flags_q <= f_d;
  end
endmodule

// File: rtl/rx_sync_fsm.sv
module rx_sync_fsm
  import rx_sync_pkg::*;
#(
  parameter int BAD_RUN   = 4,
  parameter int COMMA_RUN = 4,
  parameter int BAL_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_en,
  input  logic       chr_stb,
  input  logic       chr_bad,
  input  logic       chr_comma,
  input  logic       frame_moved,
  input  logic       wsync_hit,
  input  logic       dec_idle,
  input  logic       dec_err,
  input  logic       dec_ctl,
  output logic [1:0] st_o,
  output logic       idle_o,
  output logic       err_o,
  output logic       ctl_o
);
  sync_st_e  st_q, st_nx;
  rx_flags_t flags_q;

  logic adv, bad_now, good_comma, good_data;
  logic run_fire, bal_fire, comma_fire, lose, realign;

  assign adv        = sync_en && chr_stb;
  assign bad_now    = chr_stb && chr_bad;
  assign good_comma = chr_stb && chr_comma && !chr_bad;
  assign good_data  = chr_stb && !chr_comma && !chr_bad;

  rx_sync_runcnt #(.LIMIT(BAD_RUN)) u_bad_run (
    .clk(clk), .rst(rst), .clr(!sync_en || lose),
    .adv(adv), .hit(chr_bad), .fire(run_fire)
  );

  rx_sync_runcnt #(.LIMIT(COMMA_RUN)) u_comma_run (
    .clk(clk), .rst(rst), .clr(!sync_en),
    .adv(adv), .hit(chr_comma && !chr_bad), .fire(comma_fire)
  );

  rx_sync_balance #(.LIMIT(BAL_LIMIT)) u_balance (
    .clk(clk), .rst(rst), .clr(!sync_en || lose),
    .adv(adv), .up(chr_bad), .fire(bal_fire)
  );

  assign lose    = run_fire || bal_fire;
  assign realign = comma_fire || (good_comma && frame_moved) || (chr_stb && wsync_hit);

  always_comb begin
    st_nx = st_q;
    if (lose) begin
      st_nx = ST_LOST;
    end else begin
      unique case (st_q)
        ST_LOST:   if (good_comma) st_nx = ST_RESYNC;
        ST_RESYNC: if (good_data)  st_nx = ST_LOCKED;
        ST_LOCKED: if (realign)    st_nx = ST_RESYNC;
        default:   st_nx = ST_LOST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !sync_en) st_q <= ST_LOST;
    else                 st_q <= st_nx;
  end

  rx_sync_flags u_flags (
    .clk(clk), .rst(rst), .en(sync_en), .st_nx(st_nx), .bad_now(bad_now),
    .dec('{idle: dec_idle, err: dec_err, ctl: dec_ctl}), .flags_q(flags_q)
  );

  assign st_o   = st_q;
  assign idle_o = flags_q.idle;
  assign err_o  = flags_q.err;
  assign ctl_o  = flags_q.ctl;
endmodule

// File: rtl/rx_sync_chk.sv
module rx_sync_chk (
  input logic       clk,
  input logic       rst,
  input logic       sync_en,
  input logic       chr_stb,
  input logic       chr_bad,
  input logic       chr_comma,
  input logic       dec_idle,
  input logic       dec_err,
  input logic       dec_ctl,
  input logic [1:0] st_o,
  input logic       idle_o,
  input logic       err_o,
  input logic       ctl_o
);
  a_r1_state_legal: assert property (@(posedge clk) disable iff (rst)
    st_o != 2'd3);

  a_r2_lost_hold: assert property (@(posedge clk) disable iff (rst)
    (st_o == 2'd0 && !(sync_en && chr_stb && chr_comma && !chr_bad)) |=> st_o == 2'd0);

  a_r2_lost_exit: assert property (@(posedge clk) disable iff (rst)
    (st_o == 2'd0) |=> (st_o == 2'd0 || st_o == 2'd1));

  a_r3_resync_exit: assert property (@(posedge clk) disable iff (rst)
    (st_o == 2'd1 && !(sync_en && chr_stb && !chr_bad && !chr_comma)) |=> st_o != 2'd2);

  a_r8_resync_flags: assert property (@(posedge clk) disable iff (rst)
    (st_o == 2'd1) |-> (idle_o && err_o && ctl_o));

  a_r8_locked_err: assert property (@(posedge clk) disable iff (rst)
    (st_o == 2'd2) |-> !(err_o && ctl_o));

  a_r9_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (sync_en && !chr_stb) |=> $stable(st_o));

  a_r10_disabled: assert property (@(posedge clk) disable iff (rst)
    !sync_en |=> (st_o == 2'd0 && idle_o == $past(dec_idle)
                  && err_o == $past(dec_err) && ctl_o == $past(dec_ctl)));
endmodule

bind rx_sync_fsm rx_sync_chk u_chk (
  .clk(clk), .rst(rst), .sync_en(sync_en), .chr_stb(chr_stb), .chr_bad(chr_bad),
  .chr_comma(chr_comma), .dec_idle(dec_idle), .dec_err(dec_err), .dec_ctl(dec_ctl),
  .st_o(st_o), .idle_o(idle_o), .err_o(err_o), .ctl_o(ctl_o)
);

// File: tb/rx_sync_fsm_tb.sv
`timescale 1ns/1ps
module rx_sync_fsm_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_en = 1'b0, chr_stb = 1'b0, chr_bad = 1'b0, chr_comma = 1'b0;
  logic frame_moved = 1'b0, wsync_hit = 1'b0;
  logic dec_idle = 1'b0, dec_err = 1'b0, dec_ctl = 1'b0;
  logic [1:0] st_o;
  logic idle_o, err_o, ctl_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_sync_fsm dut_i (
    .clk(clk), .rst(rst), .sync_en(sync_en), .chr_stb(chr_stb), .chr_bad(chr_bad),
    .chr_comma(chr_comma), .frame_moved(frame_moved), .wsync_hit(wsync_hit),
    .dec_idle(dec_idle), .dec_err(dec_err), .dec_ctl(dec_ctl),
    .st_o(st_o), .idle_o(idle_o), .err_o(err_o), .ctl_o(ctl_o)
  );

  // {req, en vld bad comma moved wsync d_idle d_err d_ctl, state, idle err ctl}
  localparam int NV = 62;
  localparam logic [17:0] VEC [NV] = '{
    {4'd2, 9'b110000000, 2'd0, 3'b011}, {4'd2, 9'b111000010, 2'd0, 3'b011},
    {4'd2, 9'b110100101, 2'd1, 3'b111}, {4'd3, 9'b110110101, 2'd1, 3'b111},
    {4'd3, 9'b111000010, 2'd1, 3'b111}, {4'd3, 9'b110000101, 2'd2, 3'b101},
    {4'd8, 9'b110000000, 2'd2, 3'b000}, {4'd8, 9'b111000010, 2'd2, 3'b010},
    {4'd8, 9'b110000000, 2'd2, 3'b000}, {4'd4, 9'b110100101, 2'd2, 3'b101},
    {4'd4, 9'b110100101, 2'd2, 3'b101}, {4'd4, 9'b110100101, 2'd2, 3'b101},
    {4'd4, 9'b110100101, 2'd1, 3'b111}, {4'd5, 9'b110000000, 2'd2, 3'b000},
    {4'd5, 9'b110110101, 2'd1, 3'b111}, {4'd5, 9'b110000000, 2'd2, 3'b000},
    {4'd5, 9'b110001000, 2'd1, 3'b111}, {4'd5, 9'b110000000, 2'd2, 3'b000},
    {4'd9, 9'b101111000, 2'd2, 3'b000}, {4'd6, 9'b111000010, 2'd2, 3'b010},
    {4'd6, 9'b111000010, 2'd2, 3'b010}, {4'd6, 9'b111000010, 2'd2, 3'b010},
    {4'd6, 9'b111000010, 2'd0, 3'b011}, {4'd2, 9'b110100101, 2'd1, 3'b111},
    {4'd3, 9'b110000000, 2'd2, 3'b000}, {4'd7, 9'b111000010, 2'd2, 3'b010},
    {4'd7, 9'b111000010, 2'd2, 3'b010}, {4'd7, 9'b111000010, 2'd2, 3'b010},
    {4'd7, 9'b110000000, 2'd2, 3'b000}, {4'd7, 9'b111000010, 2'd2, 3'b010},
    {4'd7, 9'b111000010, 2'd0, 3'b011}, {4'd2, 9'b110100101, 2'd1, 3'b111},
    {4'd3, 9'b110000000, 2'd2, 3'b000}, {4'd7, 9'b110000000, 2'd2, 3'b000},
    {4'd7, 9'b110000000, 2'd2, 3'b000}, {4'd7, 9'b110000000, 2'd2, 3'b000},
    {4'd7, 9'b111000010, 2'd2, 3'b010}, {4'd7, 9'b111000010, 2'd2, 3'b010},
    {4'd7, 9'b111000010, 2'd2, 3'b010}, {4'd7, 9'b110000000, 2'd2, 3'b000},
    {4'd7, 9'b111000010, 2'd2, 3'b010}, {4'd7, 9'b111000010, 2'd0, 3'b011},
    {4'd2, 9'b110100101, 2'd1, 3'b111}, {4'd3, 9'b110000000, 2'd2, 3'b000},
    {4'd6, 9'b111000010, 2'd2, 3'b010}, {4'd6, 9'b111000010, 2'd2, 3'b010},
    {4'd6, 9'b111000010, 2'd2, 3'b010}, {4'd11, 9'b111110101, 2'd0, 3'b011},
    {4'd2, 9'b110100101, 2'd1, 3'b111}, {4'd3, 9'b110000000, 2'd2, 3'b000},
    {4'd10, 9'b010000101, 2'd0, 3'b101}, {4'd10, 9'b010000010, 2'd0, 3'b010},
    {4'd10, 9'b110000000, 2'd0, 3'b011}, {4'd2, 9'b110100101, 2'd1, 3'b111},
    {4'd3, 9'b110000000, 2'd2, 3'b000}, {4'd6, 9'b111000010, 2'd2, 3'b010},
    {4'd6, 9'b111000010, 2'd2, 3'b010}, {4'd6, 9'b111000010, 2'd2, 3'b010},
    {4'd10, 9'b010000000, 2'd0, 3'b000}, {4'd10, 9'b110100101, 2'd1, 3'b111},
    {4'd10, 9'b110000000, 2'd2, 3'b000}, {4'd10, 9'b111000010, 2'd2, 3'b010}
  };

  function automatic string req_name(input int id);
    case (id)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: state/idle/err/ctl got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic drive(input logic [8:0] s);
    {sync_en, chr_stb, chr_bad, chr_comma, frame_moved, wsync_hit,
     dec_idle, dec_err, dec_ctl} = s;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", {st_o, idle_o, err_o, ctl_o}, 5'b00_011);

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][13:5]);
      @(negedge clk);
      check(req_name(int'(VEC[k][17:14])), {st_o, idle_o, err_o, ctl_o}, VEC[k][4:0]);
    end

    // R12: shifted comma while locked; nothing may change before the edge
    drive(9'b110110101);
    #3;
    check("R12", {st_o, idle_o, err_o, ctl_o}, 5'b10_010);
    @(negedge clk);
    check("R12", {st_o, idle_o, err_o, ctl_o}, 5'b01_111);

    // R1: synchronous reset while strobing commas returns to lost
    rst = 1'b1;
    drive(9'b110100101);
    @(negedge clk);
    @(negedge clk);
    check("R1", {st_o, idle_o, err_o, ctl_o}, 5'b00_011);
    drive(9'b110000000);
    rst = 1'b0;
    @(negedge clk);
    check("R2", {st_o, idle_o, err_o, ctl_o}, 5'b00_011);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule